// File: doc/BRIEF.md
# 32-Pin GPIO Controller with Event Detection

This block is a memory-mapped general-purpose I/O controller for 32 pins. Software reaches it over a simple single-cycle 32-bit register bus. Writes take effect on the clock edge. Reads are combinational while the block is selected. Each pin has one bit in every register. The direction register gives each pin's direction, and its bit is 1 for an input. The driven output levels are changed through two atomic registers, one that sets bits and one that clears them, so no read-modify-write is needed. The pin levels are synchronized by two flops before software reads them.

Every pin can raise an event from any mix of four triggers: low level, high level, rising edge and falling edge. Events set bits in a sticky status register. Software clears a status bit by writing 1 to it. The status register is masked by an enable mask to drive one combined interrupt line. The enable mask is changed through separate set and clear registers, and both of those addresses read back the current mask.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF (all pins inputs), `pin_dir_in` is all ones, and the output data, status, enable and all four trigger masks read 0. `pin_out` is 0 and `irq` is 0.
- R2: The direction register at 0x134 is read/write. Its value appears on `pin_dir_in`, where bit n = 1 means pin n is an input.
- R3: Writing a mask to 0x194 sets those output bits. Writing a mask to 0x190 clears them. Bits written as 0 keep their value. The driven value reads back at 0x13C and appears on `pin_out`.
- R4: Offset 0x138 returns the pin levels after a two-flop synchronizer. A pin change made before clock edge k is visible after edge k+1.
- R5: The rising-edge mask (0x148) and falling-edge mask (0x14C) act independently. A pin transition of the unselected direction does not set the status bit.
- R6: The low-level mask (0x140) and high-level mask (0x144) raise an event on every cycle that the pin is at the selected level. A pin with both bits set has its status bit set permanently, whatever its level.
- R7: The status register (0x02C) is sticky and write-one-to-clear. A status bit is set on the edge after its event. A clear and an event on the same bit in the same cycle leave the bit set.
- R8: Writing to 0x034 ORs the written bits into the enable mask. Writing to 0x038 removes them. Both addresses read the mask. Status bits set whether or not they are enabled. `irq` is 1 exactly when some bit is set in both status and enable.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets, to 0x138 and to 0x13C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle while reading |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven output values |
| pin_dir_in | output | 32 | Per-pin direction, 1 = input |
| irq | output | 1 | Combined interrupt |

## Verification
Each trigger kind is driven on its own pin with the opposite stimulus as well. A rising mask meets a falling transition, and a falling mask meets a rising one. This separates the edge selections from each other and from the level logic. A held level under a high-level mask is cleared while its event is still present, which shows that a set beats a clear. The same pin is then cleared after its level is gone, which shows that clearing works at all. A pin with both level masks set is toggled to show that its status stays set. The enable tests set a status bit while it is masked and then unmask it. This shows that the status is recorded apart from the interrupt gating.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_EVT_STAT = 12'h02C;
  localparam logic [ADDR_W-1:0] A_ENA_SET  = 12'h034;
  localparam logic [ADDR_W-1:0] A_ENA_CLR  = 12'h038;
  localparam logic [ADDR_W-1:0] A_DIR      = 12'h134;
  localparam logic [ADDR_W-1:0] A_LVL_IN   = 12'h138;
  localparam logic [ADDR_W-1:0] A_DRV      = 12'h13C;
  localparam logic [ADDR_W-1:0] A_TRG_LO   = 12'h140;
  localparam logic [ADDR_W-1:0] A_TRG_HI   = 12'h144;
  localparam logic [ADDR_W-1:0] A_TRG_RISE = 12'h148;
  localparam logic [ADDR_W-1:0] A_TRG_FALL = 12'h14C;
  localparam logic [ADDR_W-1:0] A_DRV_CLR  = 12'h190;
  localparam logic [ADDR_W-1:0] A_DRV_SET  = 12'h194;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] trg_lo,
  input  logic [WIDTH-1:0] trg_hi,
  input  logic [WIDTH-1:0] trg_rise,
  input  logic [WIDTH-1:0] trg_fall,
  output logic [WIDTH-1:0] evt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic lvl_hit, edge_hit;
    assign lvl_hit  = (trg_lo[i] & ~cur[i]) | (trg_hi[i] & cur[i]);
    assign edge_hit = (trg_rise[i] & cur[i] & ~prev[i]) |
                      (trg_fall[i] & ~cur[i] & prev[i]);
    assign evt[i]   = lvl_hit | edge_hit;
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_dir_in,
  output logic              irq
);
  logic rst_sync_n;
  logic [DATA_W-1:0] lvl_cur, lvl_prev_q, evt;
  logic [DATA_W-1:0] dir_q, drv_q, ena_q, sts_q;
  logic [DATA_W-1:0] lo_q, hi_q, rise_q, fall_q;
  logic [DATA_W-1:0] dir_d, drv_d, ena_d, sts_d;
  logic [DATA_W-1:0] lo_d, hi_d, rise_d, fall_d;
  logic wr_hit;
  logic we_dir, we_drv, we_ena, we_trg;

  gpio_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_sync_n));

  gpio_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_in), .q(lvl_cur)
  );

  gpio_detect #(.WIDTH(DATA_W)) u_det (
    .cur(lvl_cur), .prev(lvl_prev_q),
    .trg_lo(lo_q), .trg_hi(hi_q), .trg_rise(rise_q), .trg_fall(fall_q),
    .evt(evt)
  );

  assign wr_hit = bus_sel & bus_wr;

  // next-state logic
  always_comb begin
    dir_d  = dir_q;
    drv_d  = drv_q;
    ena_d  = ena_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    rise_d = rise_q;
    fall_d = fall_q;
    sts_d  = sts_q;
    if (wr_hit) begin
      case (bus_addr)
        A_DIR:      dir_d  = bus_wdata;
        A_DRV_SET:  drv_d  = drv_q | bus_wdata;
        A_DRV_CLR:  drv_d  = drv_q & ~bus_wdata;
        A_ENA_SET:  ena_d  = ena_q | bus_wdata;
        A_ENA_CLR:  ena_d  = ena_q & ~bus_wdata;
        A_TRG_LO:   lo_d   = bus_wdata;
        A_TRG_HI:   hi_d   = bus_wdata;
        A_TRG_RISE: rise_d = bus_wdata;
        A_TRG_FALL: fall_d = bus_wdata;
        A_EVT_STAT: sts_d  = sts_q & ~bus_wdata;
        default: ;
      endcase
    end
    // an event on the same bit outranks a clear
    sts_d = sts_d | evt;
  end

  assign we_dir = wr_hit && (bus_addr == A_DIR);
  assign we_drv = wr_hit && ((bus_addr == A_DRV_SET) || (bus_addr == A_DRV_CLR));
  assign we_ena = wr_hit && ((bus_addr == A_ENA_SET) || (bus_addr == A_ENA_CLR));
  assign we_trg = wr_hit && ((bus_addr == A_TRG_LO) || (bus_addr == A_TRG_HI) ||
                             (bus_addr == A_TRG_RISE) || (bus_addr == A_TRG_FALL));

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dir_q      <= '1;
      drv_q      <= '0;
      ena_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      rise_q     <= '0;
      fall_q     <= '0;
      sts_q      <= '0;
      lvl_prev_q <= '0;
    end else begin
      if (we_dir) dir_q <= dir_d;
      if (we_drv) drv_q <= drv_d;
      if (we_ena) ena_q <= ena_d;
      if (we_trg) begin
        lo_q   <= lo_d;
        hi_q   <= hi_d;
        rise_q <= rise_d;
        fall_q <= fall_d;
      end
      sts_q      <= sts_d;
      lvl_prev_q <= lvl_cur;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_EVT_STAT: bus_rdata = sts_q;
        A_ENA_SET,
        A_ENA_CLR:  bus_rdata = ena_q;
        A_DIR:      bus_rdata = dir_q;
        A_LVL_IN:   bus_rdata = lvl_cur;
        A_DRV:      bus_rdata = drv_q;
        A_TRG_LO:   bus_rdata = lo_q;
        A_TRG_HI:   bus_rdata = hi_q;
        A_TRG_RISE: bus_rdata = rise_q;
        A_TRG_FALL: bus_rdata = fall_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pin_out    = drv_q;
  assign pin_dir_in = dir_q;
  assign irq        = |(sts_q & ena_q);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] sts,
  input logic [DATA_W-1:0] ena,
  input logic [DATA_W-1:0] drv,
  input logic [DATA_W-1:0] dir,
  input logic [DATA_W-1:0] lo,
  input logic [DATA_W-1:0] hi
);
  logic wr;
  logic mapped;
  assign wr = bus_sel && bus_wr;
  assign mapped = (bus_addr == A_EVT_STAT) || (bus_addr == A_ENA_SET) ||
                  (bus_addr == A_ENA_CLR)  || (bus_addr == A_DIR) ||
                  (bus_addr == A_LVL_IN)   || (bus_addr == A_DRV) ||
                  (bus_addr == A_TRG_LO)   || (bus_addr == A_TRG_HI) ||
                  (bus_addr == A_TRG_RISE) || (bus_addr == A_TRG_FALL) ||
                  (bus_addr == A_DRV_CLR)  || (bus_addr == A_DRV_SET);

  assert_drv_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_DRV_SET) |=> ((drv & $past(bus_wdata)) == $past(bus_wdata)));

  assert_drv_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_DRV_CLR) |=> ((drv & $past(bus_wdata)) == '0));

  assert_both_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(lo & hi)) == $past(lo & hi)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_EVT_STAT) |=> ((sts & $past(sts)) == $past(sts)));

  assert_ena_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_ENA_SET) |=> ((ena & $past(bus_wdata)) == $past(bus_wdata)));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(ena) && $stable(drv) && $stable(dir) &&
                         $stable(lo) && $stable(hi)));
endmodule

bind gpio_ctrl gpio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sts(sts_q), .ena(ena_q),
  .drv(drv_q), .dir(dir_q), .lo(lo_q), .hi(hi_q)
);

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_dir_in;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_dir_in(pin_dir_in), .irq(irq)
  );

  // monitor: compares queued expectations 1 ns after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = pin_out;
        2: act = pin_dir_in;
        default: act = {31'b0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    push(0, e, t);
  endtask

  task automatic port(input int k, input logic [31:0] e, input string t);
    @(negedge clk);
    push(k, e, t);
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    arst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(12'h134, 32'hFFFF_FFFF, "R1 dir");
    rd(12'h13C, 32'h0, "R1 drv");
    rd(12'h02C, 32'h0, "R1 status");
    rd(12'h034, 32'h0, "R1 enable");
    rd(12'h140, 32'h0, "R1 low mask");
    rd(12'h148, 32'h0, "R1 rise mask");
    port(2, 32'hFFFF_FFFF, "R1 pin_dir_in");
    port(1, 32'h0, "R1 pin_out");
    port(3, 32'h0, "R1 irq");

    // R2 direction
    wr(12'h134, 32'h0000_00F0);
    rd(12'h134, 32'h0000_00F0, "R2 dir readback");
    port(2, 32'h0000_00F0, "R2 pin_dir_in");

    // R3 atomic set / clear
    wr(12'h194, 32'h0000_00A5);
    rd(12'h13C, 32'h0000_00A5, "R3 set");
    wr(12'h194, 32'h0000_0F00);
    rd(12'h13C, 32'h0000_0FA5, "R3 set keeps others");
    wr(12'h190, 32'h0000_0005);
    rd(12'h13C, 32'h0000_0FA0, "R3 clear");
    port(1, 32'h0000_0FA0, "R3 pin_out");

    // R4 synchronizer latency
    set_pins(32'h1234_5678);
    rd(12'h138, 32'h0, "R4 one edge");
    rd(12'h138, 32'h1234_5678, "R4 two edges");
    set_pins(32'h0);
    idle(3);

    // R5 edges
    wr(12'h148, 32'h1);
    wr(12'h034, 32'h1);
    set_pins(32'h1);
    idle(3);
    rd(12'h02C, 32'h1, "R5 rising sets");
    port(3, 32'h1, "R8 irq enabled");
    wr(12'h02C, 32'h1);
    rd(12'h02C, 32'h0, "R7 w1c clears");
    set_pins(32'h0);
    idle(3);
    rd(12'h02C, 32'h0, "R5 fall ignored by rise mask");
    wr(12'h148, 32'h0);
    wr(12'h14C, 32'h1);
    set_pins(32'h1);
    idle(3);
    rd(12'h02C, 32'h0, "R5 rise ignored by fall mask");
    set_pins(32'h0);
    idle(3);
    rd(12'h02C, 32'h1, "R5 falling sets");
    wr(12'h02C, 32'h1);
    port(3, 32'h0, "R8 irq drops");

    // R8 enable gating
    wr(12'h148, 32'h2);
    set_pins(32'h2);
    idle(3);
    rd(12'h02C, 32'h2, "R8 status while masked");
    port(3, 32'h0, "R8 irq masked");
    wr(12'h034, 32'h2);
    port(3, 32'h1, "R8 irq after enable set");
    rd(12'h034, 32'h3, "R8 enable at set addr");
    rd(12'h038, 32'h3, "R8 enable at clear addr");
    wr(12'h038, 32'h2);
    rd(12'h034, 32'h1, "R8 enable clear");
    port(3, 32'h0, "R8 irq after enable clear");
    wr(12'h02C, 32'h2);
    rd(12'h02C, 32'h0, "R7 clear bit1");

    // R6 / R7 levels
    wr(12'h144, 32'h4);
    set_pins(32'h6);
    idle(3);
    rd(12'h02C, 32'h4, "R6 high level");
    wr(12'h02C, 32'h4);
    rd(12'h02C, 32'h4, "R7 set wins over clear");
    set_pins(32'h2);
    idle(3);
    wr(12'h02C, 32'h4);
    rd(12'h02C, 32'h0, "R7 clear after level gone");
    wr(12'h140, 32'h8);
    idle(2);
    rd(12'h02C, 32'h8, "R6 low level");
    wr(12'h140, 32'h10);
    wr(12'h144, 32'h10);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h02C, 32'h10, "R6 both levels low pin");
    set_pins(32'h12);
    idle(3);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h02C, 32'h10, "R6 both levels high pin");
    wr(12'h034, 32'h10);
    port(3, 32'h1, "R6 continuous irq");

    // R9 unmapped and read-only
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0, "R9 unmapped read");
    rd(12'h134, 32'h0000_00F0, "R9 dir unchanged");
    wr(12'h13C, 32'h0);
    rd(12'h13C, 32'h0000_0FA0, "R9 drv direct write ignored");
    rd(12'h034, 32'h11, "R9 enable unchanged");

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule